// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a host and a battery-backed static memory array. It watches four digital supply flags, each the output of a comparator: supply at or above 4.75 V, 4.50 V, 4.25 V and 3.0 V. From these it decides when the array may be accessed. While the supply is out of tolerance it holds chip-enable and write-enable toward the array inactive and stops the read-data drivers, whatever the host does. It also chooses whether the array runs from the external supply or from the backup cell.

The backup cell stays isolated from the day the part is built until the supply first climbs past the trip point. At that moment a one-time arm latch is set. Only a dedicated factory-reset input clears it. Once the supply is back above the full-function level, access is held off for a recovery interval; a fresh dip during that interval starts it over. A parameter selects one of two tolerance variants: a 5% part or a 10% part. It decides which flags act as the trip point and as the full-function level.

Top module: `pfp_seq`

## Requirements
- R1: Whenever `status` is not NORMAL (code 0), `arr_ce_n` and `arr_we_n` are 1 and `host_rdata_oe` is 0, for any value of the host controls.
- R2: After the trip-point flag falls and stays low, the block becomes protected (`arr_we_n`=1) exactly FILT+3 clock cycles later. This is within 1.5 us at the configured clock.
- R3: `pwr_ext` is 1 while the filtered 3.0 V flag is high and the block is not in BACKUP (code 2). `pwr_bat` is 1 only in BACKUP while armed. The two are never 1 together.
- R4: `armed` sets once the filtered trip-point flag is high. The ordinary reset does not clear it, and neither does loss of every supply flag; only `factory_rst` clears it. With `armed` at 0, `pwr_bat` stays 0 and BACKUP is not entered, even with every flag low.
- R5: Once the full-function flag is back and the trip flag is high, `status` reads RECOVER (code 3) for exactly HOLD cycles, where HOLD = CLK_HZ*HOLD_US/1e6. Then it reads NORMAL. If the full-function flag drops during RECOVER, the block returns to PROTECT (code 1), and the next recovery runs a full HOLD again.
- R6: With NARROW_TOL=1, the trip flag is `vcc_ge_450` and the full-function flag is `vcc_ge_475`. With NARROW_TOL=0, the trip flag is `vcc_ge_425` and the full-function flag is `vcc_ge_450`. With the supply between trip and full, a protected block stays protected and a NORMAL block stays NORMAL.
- R7: A flag change lasting fewer than FILT cycles has no effect on `status`.
- R8: In NORMAL, `arr_ce_n` and `arr_we_n` follow the host. `host_rdata_oe` is 1 and `host_rdata` equals `mem_rdata` only when `host_ce_n`=0, `host_oe_n`=0 and `host_we_n`=1.
- R9: After `rst`, `status` reads PROTECT (code 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the arm latch) |
| factory_rst | input | 1 | Synchronous clear of the arm latch |
| vcc_ge_300 | input | 1 | Comparator flag: supply at or above 3.0 V |
| vcc_ge_425 | input | 1 | Comparator flag: supply at or above 4.25 V |
| vcc_ge_450 | input | 1 | Comparator flag: supply at or above 4.50 V |
| vcc_ge_475 | input | 1 | Comparator flag: supply at or above 4.75 V |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_rdata | input | DW | Read data from the array |
| arr_ce_n | output | 1 | Gated chip enable to the array |
| arr_we_n | output | 1 | Gated write enable to the array |
| host_rdata | output | DW | Read data toward the host (0 when not driven) |
| host_rdata_oe | output | 1 | Drive enable for the host data pins |
| pwr_ext | output | 1 | Select the external supply |
| pwr_bat | output | 1 | Select the backup cell |
| armed | output | 1 | Arm latch state |
| status | output | 2 | 0 NORMAL, 1 PROTECT, 2 BACKUP, 3 RECOVER |

## Verification
Any wrong state in the control machine appears on `status` at once, and on the gated enables in the same cycle. A NORMAL state entered too early passes a host write through while the supply is still below the full-function level. A wrong count in the hold timer shows as a RECOVER run that is longer or shorter than HOLD, measured to the cycle. A stuck or prematurely cleared arm latch shows on `armed` and on `pwr_bat` as soon as all flags drop. A glitch filter that is too short or too long shows as a protection latency different from FILT+3 cycles, or as a short pulse that moves `status`.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_PROTECT = 2'd1,
        ST_BACKUP  = 2'd2,
        ST_RECOVER = 2'd3
    } pfp_state_e;

    localparam int NFLAG  = 4;
    localparam int F_300  = 0;
    localparam int F_425  = 1;
    localparam int F_450  = 2;
    localparam int F_475  = 3;

    typedef struct packed {
        logic full_ok;
        logic trip_ok;
        logic swo_ok;
    } pfp_levels_t;

    function automatic int hold_cycles(longint clk_hz, longint hold_us);
        longint c;
        c = (clk_hz * hold_us) / 64'd1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/pfp_flag_filter.sv
module pfp_flag_filter #(
    parameter int FILT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = (FILT > 1) ? $clog2(FILT) : 1;

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            level <= 1'b0;
            cnt   <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == level) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT - 1)) begin
                level <= s2;
                cnt   <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // the filtered level only ever moves to the synchronized value
    assert_filter_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> (level == $past(s2)));

endmodule

// File: rtl/pfp_hold_timer.sv
module pfp_hold_timer #(
    parameter int TERM = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(TERM + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end

    assign done = run && (cnt == CW'(TERM - 1));

endmodule

// File: rtl/pfp_ctrl.sv
module pfp_ctrl
    import pfp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        factory_rst,
    input  pfp_levels_t lv,
    input  logic        hold_done,
    output pfp_state_e  state,
    output logic        armed
);
    pfp_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL:
                if (!lv.trip_ok)
                    nxt = (!lv.swo_ok && armed) ? ST_BACKUP : ST_PROTECT;
            ST_PROTECT:
                if (!lv.swo_ok && armed)            nxt = ST_BACKUP;
                else if (lv.full_ok && lv.trip_ok)  nxt = ST_RECOVER;
            ST_BACKUP:
                if (lv.swo_ok || !armed)            nxt = ST_PROTECT;
            ST_RECOVER:
                if (!lv.full_ok || !lv.trip_ok)     nxt = ST_PROTECT;
                else if (hold_done)                 nxt = ST_NORMAL;
            default:                                nxt = ST_PROTECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PROTECT;
        else     state <= nxt;
    end

    // one-time arm latch: untouched by rst, cleared only by factory_rst
    always_ff @(posedge clk) begin
        if (factory_rst)     armed <= 1'b0;
        else if (lv.trip_ok) armed <= 1'b1;
    end

    assert_fail_protect_R2: assert property (@(posedge clk) disable iff (rst)
        !lv.trip_ok |=> (state != ST_NORMAL));

    assert_normal_after_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && $past(state) != ST_NORMAL) |-> ($past(hold_done) && $past(lv.full_ok)));

    assert_arm_clear_source_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) |-> $past(factory_rst));

endmodule

// File: rtl/pfp_seq.sv
module pfp_seq
    import pfp_pkg::*;
#(
    parameter longint CLK_HZ     = 50_000_000,
    parameter longint HOLD_US    = 125_000,
    parameter int     FILT       = 4,
    parameter bit     NARROW_TOL = 1'b1,
    parameter int     DW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          factory_rst,
    input  logic          vcc_ge_300,
    input  logic          vcc_ge_425,
    input  logic          vcc_ge_450,
    input  logic          vcc_ge_475,
    input  logic          host_ce_n,
    input  logic          host_we_n,
    input  logic          host_oe_n,
    input  logic [DW-1:0] mem_rdata,
    output logic          arr_ce_n,
    output logic          arr_we_n,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdata_oe,
    output logic          pwr_ext,
    output logic          pwr_bat,
    output logic          armed,
    output logic [1:0]    status
);
    localparam int HOLD = hold_cycles(CLK_HZ, HOLD_US);

    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] flt;
    pfp_levels_t      lv;
    pfp_state_e       state;
    logic             hold_done;
    logic             prot;
    logic             unused_flag;

    assign raw_flags = {vcc_ge_475, vcc_ge_450, vcc_ge_425, vcc_ge_300};

    for (genvar i = 0; i < NFLAG; i++) begin : g_filt
        pfp_flag_filter #(.FILT(FILT)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_flags[i]),
            .level (flt[i])
        );
    end

    if (NARROW_TOL) begin : g_tol5
        assign lv.full_ok   = flt[F_475];
        assign lv.trip_ok   = flt[F_450];
        assign unused_flag  = flt[F_425];
    end else begin : g_tol10
        assign lv.full_ok   = flt[F_450];
        assign lv.trip_ok   = flt[F_425];
        assign unused_flag  = flt[F_475];
    end
    assign lv.swo_ok = flt[F_300];

    pfp_hold_timer #(.TERM(HOLD)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_RECOVER),
        .done (hold_done)
    );

    pfp_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .factory_rst (factory_rst),
        .lv          (lv),
        .hold_done   (hold_done),
        .state       (state),
        .armed       (armed)
    );

    assign prot          = (state != ST_NORMAL);
    assign arr_ce_n      = prot | host_ce_n;
    assign arr_we_n      = prot | host_we_n;
    assign host_rdata_oe = !prot && !host_ce_n && !host_oe_n && host_we_n;
    assign host_rdata    = host_rdata_oe ? mem_rdata : '0;
    assign pwr_bat       = (state == ST_BACKUP) && armed;
    assign pwr_ext       = lv.swo_ok && (state != ST_BACKUP);
    assign status        = state;

    assert_src_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(pwr_ext && pwr_bat));

    assert_no_backup_unarmed_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BACKUP) |-> $past(armed));

    assert_array_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (status != 2'd0) |-> (arr_we_n && arr_ce_n && !host_rdata_oe));

endmodule

// File: tb/tb_pfp_seq.sv
module tb_pfp_seq;
    localparam int     PER   = 10;
    localparam longint CLKHZ = 100_000_000;
    localparam longint HUS   = 10;
    localparam int     FILT  = 4;
    localparam int     HOLD  = 1000;
    localparam int     FAIL_CYC = 150;

    logic clk = 0;
    logic rst, factory_rst;
    logic v300, v425, v450, v475;
    logic ce_n, we_n, oe_n;
    logic [7:0] mrd;
    logic arr_ce_n, arr_we_n, rd_oe, p_ext, p_bat, armed;
    logic [7:0] rd;
    logic [1:0] status;
    logic a_ce_y, a_we_y, oe_y, e_y, b_y, arm_y;
    logic [7:0] rd_y;
    logic [1:0] status_y;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(PER/2) clk = ~clk;

    pfp_seq #(.CLK_HZ(CLKHZ), .HOLD_US(HUS), .FILT(FILT), .NARROW_TOL(1'b1), .DW(8)) dut (
        .clk(clk), .rst(rst), .factory_rst(factory_rst),
        .vcc_ge_300(v300), .vcc_ge_425(v425), .vcc_ge_450(v450), .vcc_ge_475(v475),
        .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n), .mem_rdata(mrd),
        .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .host_rdata(rd), .host_rdata_oe(rd_oe),
        .pwr_ext(p_ext), .pwr_bat(p_bat), .armed(armed), .status(status));

    pfp_seq #(.CLK_HZ(CLKHZ), .HOLD_US(HUS), .FILT(FILT), .NARROW_TOL(1'b0), .DW(8)) dut_y (
        .clk(clk), .rst(rst), .factory_rst(factory_rst),
        .vcc_ge_300(v300), .vcc_ge_425(v425), .vcc_ge_450(v450), .vcc_ge_475(v475),
        .host_ce_n(ce_n), .host_we_n(we_n), .host_oe_n(oe_n), .mem_rdata(mrd),
        .arr_ce_n(a_ce_y), .arr_we_n(a_we_y), .host_rdata(rd_y), .host_rdata_oe(oe_y),
        .pwr_ext(e_y), .pwr_bat(b_y), .armed(arm_y), .status(status_y));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic recover_len(output int n);
        int guard = 0;
        while (status != 2'd3 && guard < 100) begin @(negedge clk); guard++; end
        n = 0;
        while (status == 2'd3 && n < HOLD + 50) begin @(posedge clk); n++; @(negedge clk); end
    endtask

    task automatic t_reset;
        ce_n = 0; we_n = 0; oe_n = 1;
        cyc(2);
        chk(status == 2'd1, "R9 reset status", status, 1);
        chk(arr_we_n && arr_ce_n, "R1 gated after reset", {arr_ce_n, arr_we_n}, 3);
        chk(!armed, "R4 armed after factory reset", armed, 0);
        chk(!p_bat && !p_ext, "R3 no source with flags low", {p_ext, p_bat}, 0);
        ce_n = 1; we_n = 1;
    endtask

    task automatic t_fresh;
        v300 = 1; cyc(20);
        chk(p_ext && !p_bat, "R3 external above 3.0V", {p_ext, p_bat}, 2);
        chk(!armed, "R4 not armed below trip", armed, 0);
        v425 = 1; cyc(20);
        chk(!armed, "R6 4.25 not trip in 5pct variant", armed, 0);
        v450 = 1; cyc(20);
        chk(armed, "R4 armed above trip", armed, 1);
        chk(status == 2'd1, "R6 stays protected below full level", status, 1);
        chk(status_y == 2'd3, "R6 10pct variant recovers at 4.5", status_y, 3);
    endtask

    task automatic t_recover;
        int n;
        v475 = 1;
        recover_len(n);
        chk(n == HOLD, "R5 recovery hold length", n, HOLD);
        chk(status == 2'd0, "R5 normal after hold", status, 0);
    endtask

    task automatic t_normal;
        ce_n = 0; we_n = 0; oe_n = 1; #1;
        chk(!arr_ce_n && !arr_we_n && !rd_oe, "R8 write passes", {arr_ce_n, arr_we_n, rd_oe}, 0);
        we_n = 1; oe_n = 0; mrd = 8'hA5; #1;
        chk(rd_oe && rd == 8'hA5, "R8 read drives data", rd, 8'hA5);
        we_n = 0; #1;
        chk(!rd_oe, "R8 write disables drivers", rd_oe, 0);
        ce_n = 1; we_n = 1; oe_n = 1;
        cyc(1);
    endtask

    task automatic t_band;
        v475 = 0; cyc(30);
        chk(status == 2'd0, "R6 hysteresis band stays normal", status, 0);
        ce_n = 0; we_n = 0; #1;
        chk(!arr_we_n, "R6 write allowed in band", arr_we_n, 0);
        ce_n = 1; we_n = 1;
        v475 = 1; cyc(20);
    endtask

    task automatic t_glitch;
        v450 = 0; cyc(FILT - 1); v450 = 1;
        cyc(20);
        chk(status == 2'd0, "R7 short trip glitch ignored", status, 0);
    endtask

    task automatic t_fail;
        int n = 0;
        ce_n = 0; we_n = 0; oe_n = 0;
        v475 = 0; v450 = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!arr_we_n && n < 200);
        chk(n == FILT + 3, "R2 protect latency", n, FILT + 3);
        chk(n <= FAIL_CYC, "R2 within 1.5us", n, FAIL_CYC);
        we_n = 1; #1;
        chk(!rd_oe && arr_ce_n, "R1 host read ignored when protected", {arr_ce_n, rd_oe}, 2);
        chk(status == 2'd1, "R1 protect state", status, 1);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic t_dip;
        int n;
        v450 = 1; cyc(30);
        chk(status == 2'd1, "R6 trip alone does not resume", status, 1);
        v475 = 1;
        while (status != 2'd3) @(negedge clk);
        cyc(300);
        v475 = 0; cyc(20);
        chk(status == 2'd1, "R5 dip aborts recovery", status, 1);
        v475 = 1;
        recover_len(n);
        chk(n == HOLD, "R5 hold restarts in full", n, HOLD);
    endtask

    task automatic t_backup;
        v475 = 0; v450 = 0; v425 = 0; v300 = 0;
        cyc(30);
        chk(status == 2'd2, "R3 backup status", status, 2);
        chk(p_bat && !p_ext, "R3 backup source selected", {p_ext, p_bat}, 1);
        rst = 1; cyc(3); rst = 0;
        chk(armed, "R4 arm survives reset", armed, 1);
        cyc(20);
        chk(p_bat && status == 2'd2, "R4 backup again after reset", status, 2);
    endtask

    task automatic t_factory;
        factory_rst = 1; cyc(1); factory_rst = 0;
        cyc(3);
        chk(!armed, "R4 factory reset clears arm", armed, 0);
        chk(!p_bat && status == 2'd1, "R4 no backup while unarmed", status, 1);
        cyc(20);
        chk(!p_bat && !armed, "R4 stays unarmed with flags low", {armed, p_bat}, 0);
    endtask

    initial begin
        #(PER * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; factory_rst = 1;
        v300 = 0; v425 = 0; v450 = 0; v475 = 0;
        ce_n = 1; we_n = 1; oe_n = 1; mrd = 8'h00;
        cyc(5);
        rst = 0; factory_rst = 0;
        t_reset();
        t_fresh();
        t_recover();
        t_normal();
        t_band();
        t_glitch();
        t_fail();
        t_dip();
        t_backup();
        t_factory();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule